// File: doc/BRIEF.md
# Coded Mark Inversion Line Encoder

This block turns a serial NRZ bit stream at 2.048 Mbit/s into Coded Mark Inversion line symbols. Each data bit becomes two half-bit symbols. The block runs on a clock at twice the bit rate that is phase-aligned to the transmit bit clock. It receives the bit clock as a level, finds the falling edge of that clock, and samples the data bit and a violation request at that edge. About one bit period later it drives the two half-bits on a differential pair of line outputs, together with an output-enable.

A space is sent as a low half followed by a high half. Each mark fills its whole bit at one level, and successive marks alternate between high and low. The violation request makes the block break the code on purpose. It can do this on a mark or on a space:
- A violating mark repeats the level of the previous mark.
- A violating space inverts the usual half-bit order.

A violation request held for a long run is honoured only for a limited number of consecutive bits. After that it is ignored until the request drops.

While reset is low, the output-enable is low, which puts the line pair into high impedance. Analog pulse shaping, the line driver itself and clock generation are outside this block.

Top module: `cmi_line_encoder`

## Requirements
- R1: The data bit and the violation request are sampled only at the fast-clock rising edge where the bit clock is seen low after being high. Their values while the bit clock is high have no effect.
- R2: A bit sampled at fast-clock edge t appears on `line_a` as its first half-bit after edge t+2 and as its second half-bit after edge t+3. This is one bit period of latency.
- R3: A space with no granted violation is sent on `line_a` as 0 in the first half and 1 in the second half.
- R4: A mark with no granted violation holds one level for both halves, and that level is the inverse of the previous mark's level. After reset the first mark is sent at level 1.
- R5: A mark with a granted violation repeats the previous mark's level in both halves. It does not change the alternation, so the next normal mark is the inverse of that repeated level.
- R6: A space with a granted violation is sent on `line_a` as 1 in the first half and 0 in the second half.
- R7: Within a run of consecutive sampled bits that have the violation request high, violations are granted for the first 5 bits only. Bits from the 6th onward are encoded as normal until a bit is sampled with the request low.
- R8: While `line_oe` is high, `line_b` is the complement of `line_a`.
- R9: While `rst_n` is low, `line_oe`, `line_a` and `line_b` are all 0. `line_oe` is 1 after the first fast-clock edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Encoder clock at twice the bit rate, phase-aligned to the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock, sampled as a level |
| tx_bit | input | 1 | NRZ data bit, captured at the bit clock falling edge |
| viol_req | input | 1 | Violation request for the bit being captured |
| line_a | output | 1 | Positive sense of the line signal |
| line_b | output | 1 | Complement of `line_a` while enabled |
| line_oe | output | 1 | Output-enable for the line pair; low means high impedance |

## Verification
The properties and the latency in R2 assume the following about the bit clock:
- It toggles on every fast-clock cycle.
- It is sampled cleanly by the fast clock.
- It stays low when reset is released.
Under these conditions a falling edge is seen on every second fast-clock edge. The stimulus meets this by changing the bit clock, data and violation request only at fast-clock falling edges, from a single per-bit task. That task also drives inverted decoy values on the data and request while the bit clock is high, so R1 is exercised on every bit.

// File: rtl/cmi_enc_pkg.sv
package cmi_enc_pkg;

    typedef struct packed {
        logic first;
        logic second;
    } halfpair_t;

    typedef struct packed {
        logic      bclk;
        halfpair_t hold;
        logic      mid;
        logic      a;
        logic      b;
        logic      oe;
        logic      pol;
    } enc_state_t;

endpackage

// File: rtl/cmi_viol_limiter.sv
module cmi_viol_limiter #(
    parameter int MAX_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic req,
    output logic grant
);
    localparam int RW = $clog2(MAX_RUN + 2);
    localparam logic [RW-1:0] RUN_CAP = RW'(MAX_RUN);

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        grant = req && (run_q < RUN_CAP);
        run_d = run_q;
        if (strobe) begin
            if (!req)
                run_d = '0;
            else if (run_q < RUN_CAP)
                run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // consecutive granted strobes, counted apart from the run counter
    logic [RW-1:0] gcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gcnt_q <= '0;
        else if (strobe)
            gcnt_q <= (req && grant && gcnt_q < RUN_CAP) ? gcnt_q + 1'b1 : '0;
    end

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && grant) |-> (gcnt_q < RUN_CAP)); // R7

endmodule

// File: rtl/cmi_symbol_map.sv
module cmi_symbol_map
    import cmi_enc_pkg::*;
(
    input  logic      bit_i,
    input  logic      viol_i,
    input  logic      pol_i,
    output halfpair_t sym_o,
    output logic      pol_o
);
    logic lvl;

    always_comb begin
        lvl   = viol_i ? pol_i : ~pol_i;
        pol_o = pol_i;
        if (bit_i) begin
            sym_o.first  = lvl;
            sym_o.second = lvl;
            pol_o        = lvl;
        end else begin
            sym_o.first  = viol_i;
            sym_o.second = ~viol_i;
        end
    end

endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder
    import cmi_enc_pkg::*;
#(
    parameter int MAX_VIOL_RUN = 5
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic tx_bclk,
    input  logic tx_bit,
    input  logic viol_req,
    output logic line_a,
    output logic line_b,
    output logic line_oe
);
    enc_state_t st_d, st_q;
    logic       fall;
    logic       grant;
    halfpair_t  m_sym;
    logic       m_pol;

    assign fall = st_q.bclk & ~tx_bclk;

    cmi_viol_limiter #(.MAX_RUN(MAX_VIOL_RUN)) u_limit (
        .clk    (clk2x),
        .rst_n  (rst_n),
        .strobe (fall),
        .req    (viol_req),
        .grant  (grant)
    );

    cmi_symbol_map u_map (
        .bit_i  (tx_bit),
        .viol_i (grant),
        .pol_i  (st_q.pol),
        .sym_o  (m_sym),
        .pol_o  (m_pol)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bclk = tx_bclk;
        st_d.oe   = 1'b1;
        if (fall) begin
            st_d.a    = st_q.hold.first;
            st_d.b    = ~st_q.hold.first;
            st_d.mid  = st_q.hold.second;
            st_d.hold = m_sym;
            st_d.pol  = m_pol;
        end else begin
            st_d.a = st_q.mid;
            st_d.b = ~st_q.mid;
        end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.hold <= '{first: 1'b0, second: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_a  = st_q.a;
    assign line_b  = st_q.b;
    assign line_oe = st_q.oe;

    AST_LINE_COMPLEMENT: assert property (@(posedge clk2x) disable iff (!rst_n)
        line_oe |-> (line_a != line_b)); // R8
    AST_OE_AFTER_RESET: assert property (@(posedge clk2x) disable iff (!rst_n)
        rst_n |=> line_oe); // R9
    AST_SPACE_SHAPE: assert property (@(posedge clk2x) disable iff (!rst_n)
        (fall && !tx_bit) |-> (m_sym.first != m_sym.second)); // R3
    AST_SPACE_VIOL: assert property (@(posedge clk2x) disable iff (!rst_n)
        (fall && !tx_bit && grant) |-> (m_sym.first && !m_sym.second)); // R6
    AST_MARK_ALTERNATES: assert property (@(posedge clk2x) disable iff (!rst_n)
        (fall && tx_bit && !grant) |=> (st_q.pol != $past(st_q.pol))); // R4
    AST_MARK_VIOL_HOLDS: assert property (@(posedge clk2x) disable iff (!rst_n)
        (fall && tx_bit && grant) |=> $stable(st_q.pol)); // R5

endmodule

// File: tb/cmi_line_encoder_test.sv
module cmi_line_encoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bclk = 1'b0;
    logic tx_bit = 1'b0;
    logic viol_req = 1'b0;
    logic line_a, line_b, line_oe;

    int n_tests = 0;
    int n_fail = 0;

    logic [1:0] exp_h [0:1023];
    string      lab   [0:1023];
    int         idx;
    logic       pol_m;
    int         run_m;
    logic [15:0] lfsr;

    always #4 clk = ~clk;

    cmi_line_encoder uut (
        .clk2x (clk), .rst_n (rst_n), .tx_bclk (tx_bclk), .tx_bit (tx_bit),
        .viol_req (viol_req), .line_a (line_a), .line_b (line_b), .line_oe (line_oe)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic seg_reset();
        pol_m = 1'b0;
        run_m = 0;
        idx   = 0;
    endtask

    // One bit period. While the bit clock is high, decoys (inverted values) are
    // driven; the real values are set with the fall (R1). Output halves are
    // checked at the R2 latency.
    task automatic send_bit(input logic b, input logic v);
        logic g;
        logic lvl;
        logic [1:0] h;
        g = v && (run_m < 5);
        run_m = v ? ((run_m < 5) ? run_m + 1 : 5) : 0;
        if (b) begin
            lvl = g ? pol_m : ~pol_m;
            h = {lvl, lvl};
            pol_m = lvl;
            lab[idx] = g ? "R5" : "R4";
        end else begin
            h = g ? 2'b10 : 2'b01;
            lab[idx] = g ? "R6" : "R3";
        end
        if (v && !g) lab[idx] = "R7";
        exp_h[idx] = h;
        tx_bclk = 1'b1; tx_bit = ~b; viol_req = ~v;
        @(negedge clk);
        if (idx >= 2) begin
            chk(line_a, exp_h[idx-2][0], lab[idx-2], "second half (R1/R2)");
            chk(line_b, ~line_a, "R8", "complement");
            chk(line_oe, 1'b1, "R9", "enable");
        end
        tx_bclk = 1'b0; tx_bit = b; viol_req = v;
        @(negedge clk);
        if (idx >= 1)
            chk(line_a, exp_h[idx-1][1], lab[idx-1], "first half (R1/R2)");
        idx++;
    endtask

    task automatic flush();
        send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(line_oe, 1'b0, "R9", "oe in reset");
        chk(line_a, 1'b0, "R9", "a in reset");
        chk(line_b, 1'b0, "R9", "b in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_oe, 1'b1, "R9", "oe after release");
        seg_reset();

        // plain spaces then plain marks (R3, R4)
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
        // mark violations keep the alternation (R5)
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        // space violations (R6)
        for (int i = 0; i < 4; i++) send_bit(1'b0, i[0]);
        // long request runs: 8 marks then 9 spaces (R7)
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 6; i++) send_bit(i[1], 1'b1);
        // pseudo-random stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0], lfsr[3] & (lfsr[7] | lfsr[9]));
        end
        flush();

        // reset in mid-stream (R9), then first mark is high again (R4)
        send_bit(1'b1, 1'b0);
        rst_n = 1'b0; tx_bclk = 1'b0;
        repeat (2) @(negedge clk);
        chk(line_oe, 1'b0, "R9", "oe in second reset");
        chk(line_a, 1'b0, "R9", "a in second reset");
        chk(line_b, 1'b0, "R9", "b in second reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_oe, 1'b1, "R9", "oe after second release");
        seg_reset();
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        flush();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule